// File: doc/BRIEF.md
# Cascadable Serial Fault Readout Register

This block is the diagnostic side of a four-channel power driver. Sixteen fault inputs, four kinds of fault for each of four output stages, are caught in a sticky parallel register. A host reads them over a serial port made of an active-low select, a serial clock, a data input and a data output. Several copies can be chained by wiring one device's data output to the next device's data input.

When select falls while the serial clock is low, a gate flip-flop is set. While it is set, the output carries one flag bit: the OR of this device's own faults and the upstream data input. A fault anywhere in the chain is therefore visible at the last device before any clock is given. The first rising serial clock clears the gate and empties the parallel register. On that same edge the output switches to the first of the device's 16 fault bits. Later edges shift the device's bits out and then pass the upstream device's bits through.

The serial pins are synchronised to a faster system clock and edge-detected there. A fault that arrives in the same system cycle as the clear is kept.

Top module: `fault_readout`

## Requirements
- R1: While `rst` is high, `do_oe` and `do_o` are 0.
- R2: `do_oe` is 1 exactly while the synchronised `cs_n` is low. `do_o` is 0 whenever `do_oe` is 0.
- R3: A fault input held high for a single system cycle is kept in the parallel register until the next clear.
- R4: If `sclk` is low when `cs_n` falls, the gate is set. Before the first rising `sclk`, `do_o` then equals the OR of all 16 captured bits ORed with `di`.
- R5: If `sclk` is high when `cs_n` falls, the gate stays clear. `do_o` shows serial bit 0 and ignores `di`.
- R6: The first rising `sclk` after `cs_n` falls clears the gate and does not shift, so `do_o` then shows serial bit 0.
- R7: Each later rising `sclk` while `cs_n` is low shifts by one. Serial bit k (k = 0..15) is fault input index k, where index = stage*4 + kind, so stage 0 kind 0 comes first.
- R8: After the device's 16 bits, the bits received on `di` follow on `do_o` in the order they arrived.
- R9: The first rising `sclk` after `cs_n` falls clears the parallel register. A select cycle with no clock leaves it intact.
- R10: A fault asserted in the same system cycle as the clear stays captured.
- R11: Faults that arrive during a read do not change the bits of that read. They are captured and show up in the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| di | input | 1 | Serial data from the upstream device |
| fault_in | input | 16 | Fault inputs, index = stage*4 + kind |
| do_o | output | 1 | Serial data / flag output |
| do_oe | output | 1 | Output enable for `do_o` |

## Verification
Two functions can fall in one system cycle: the clear of the parallel register on the first serial clock edge, and the capture of a new fault. The bench raises `sclk`, counts the two synchroniser stages and places a one-cycle fault pulse on exactly the edge where the clear is applied. A following select-only probe must show the flag set, and a full read must show that fault bit and no other. A second overlap is a fault arriving in the middle of a shift. That read must not show it, and the next read must.

// File: rtl/fault_readout_pkg.sv
package fault_readout_pkg;

    localparam int STAGES = 4;
    localparam int KINDS  = 4;
    localparam int NBITS  = STAGES * KINDS;

    typedef logic [NBITS-1:0] fault_vec_t;

    // Synchronised pin levels and detected edges
    typedef struct packed {
        logic cs_low;
        logic cs_fall;
        logic clk_high;
        logic clk_rise;
        logic di;
    } pin_evt_t;

    // Serial position of a fault: stages in order, kinds in order within a stage
    function automatic int fault_pos(input int stage, input int kind);
        return stage * KINDS + kind;
    endfunction

endpackage

// File: rtl/fr_sync.sv
module fr_sync #(
    parameter int W = 3,
    parameter int DEPTH = 2,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) chain[i] <= INIT;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[DEPTH-1];
endmodule

// File: rtl/fr_edge.sv
module fr_edge
    import fault_readout_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] s,     // {cs_n, sclk, di} after synchronisation
    output pin_evt_t   ev
);
    logic prev_cs_n;
    logic prev_sclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_cs_n <= 1'b1;
            prev_sclk <= 1'b0;
        end else begin
            prev_cs_n <= s[2];
            prev_sclk <= s[1];
        end
    end

    always_comb begin
        ev.cs_low   = ~s[2];
        ev.cs_fall  = prev_cs_n & ~s[2];
        ev.clk_high = s[1];
        ev.clk_rise = ~prev_sclk & s[1];
        ev.di       = s[0];
    end
endmodule

// File: rtl/fr_capture.sv
module fr_capture
    import fault_readout_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fault_vec_t fault_in,
    input  logic       clr,
    output fault_vec_t par
);
    fault_vec_t nxt;

    // On a clear, faults present in that cycle are kept
    for (genvar st = 0; st < STAGES; st++) begin : g_stage
        for (genvar kd = 0; kd < KINDS; kd++) begin : g_kind
            localparam int P = fault_pos(st, kd);
            assign nxt[P] = clr ? fault_in[P] : (par[P] | fault_in[P]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) par <= '0;
        else     par <= nxt;
    end
endmodule

// File: rtl/fr_shifter.sv
module fr_shifter
    import fault_readout_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pin_evt_t   ev,
    input  fault_vec_t par,
    output logic       gate,
    output logic       clr,
    output logic       do_o,
    output logic       do_oe
);
    fault_vec_t shreg;
    logic       flag;
    logic       first_pending;

    assign clr = ev.clk_rise & first_pending & ~ev.cs_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg         <= '0;
            flag          <= 1'b0;
            gate          <= 1'b0;
            first_pending <= 1'b0;
        end else if (ev.cs_fall) begin
            flag          <= |par;
            gate          <= ~ev.clk_high;
            shreg         <= par;
            first_pending <= 1'b1;
        end else if (ev.clk_rise) begin
            gate          <= 1'b0;
            first_pending <= 1'b0;
            if (ev.cs_low && !first_pending)
                shreg <= {ev.di, shreg[NBITS-1:1]};
        end
    end

    assign do_oe = ev.cs_low;
    assign do_o  = ev.cs_low & (gate ? (flag | ev.di) : shreg[0]);
endmodule

// File: rtl/fault_readout.sv
module fault_readout
    import fault_readout_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             di,
    input  logic [NBITS-1:0] fault_in,
    output logic             do_o,
    output logic             do_oe
);
    logic [2:0] pins_s;
    pin_evt_t   ev;
    fault_vec_t par;
    logic       gate;
    logic       clr;

    fr_sync #(.W(3), .DEPTH(SYNC_DEPTH), .INIT(3'b100)) u_sync (
        .clk(clk), .rst(rst), .d({cs_n, sclk, di}), .q(pins_s)
    );

    fr_edge u_edge (
        .clk(clk), .rst(rst), .s(pins_s), .ev(ev)
    );

    fr_capture u_cap (
        .clk(clk), .rst(rst), .fault_in(fault_in), .clr(clr), .par(par)
    );

    fr_shifter u_shift (
        .clk(clk), .rst(rst), .ev(ev), .par(par),
        .gate(gate), .clr(clr), .do_o(do_o), .do_oe(do_oe)
    );
endmodule

// File: rtl/fault_readout_chk.sv
module fault_readout_chk
    import fault_readout_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input pin_evt_t   ev,
    input logic       gate,
    input logic       clr,
    input fault_vec_t par,
    input fault_vec_t fault_in,
    input logic       do_oe
);
    // R2
    oe_on_select_chk: assert property (@(posedge clk) disable iff (rst)
        ev.cs_fall |-> do_oe);

    // R4
    gate_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.cs_fall && !ev.clk_high) |=> gate);

    // R5
    gate_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.cs_fall && ev.clk_high) |=> !gate);

    // R6
    gate_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.clk_rise && !ev.cs_fall) |=> !gate);

    // R9
    clear_keep_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (par == $past(fault_in)));

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((par & $past(par)) == $past(par)));
endmodule

bind fault_readout fault_readout_chk u_chk (
    .clk(clk), .rst(rst), .ev(ev), .gate(gate), .clr(clr),
    .par(par), .fault_in(fault_in), .do_oe(do_oe)
);

// File: tb/fault_readout_test.sv
`timescale 1ns/1ps
module fault_readout_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic [15:0] f_dn = '0;
    logic [15:0] f_up = '0;
    logic do_dn, oe_dn, do_up, oe_up;
    int checks = 0;
    int errs = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fault_readout uut_up (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .di(1'b0),
        .fault_in(f_up), .do_o(do_up), .do_oe(oe_up)
    );

    fault_readout uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .di(do_up),
        .fault_in(f_dn), .do_o(do_dn), .do_oe(oe_dn)
    );

    // {upstream pattern, downstream pattern}
    localparam logic [31:0] VEC [4] = '{
        32'h0000_0001, 32'h8000_0000, 32'hA5C3_0F00, 32'h0000_0000
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic inject(input logic [15:0] dn, input logic [15:0] up);
        @(negedge clk); f_dn = dn; f_up = up;
        @(negedge clk); f_dn = '0; f_up = '0;
    endtask

    // Select without clocking: only the flag is seen
    task automatic flag_probe(input string req, input logic exp);
        cs_n = 1'b0; waitn(8);
        chk(req, do_dn, exp);
        cs_n = 1'b1; waitn(8);
    endtask

    task automatic read_chain(input logic [15:0] dn, input logic [15:0] up,
                              input logic [15:0] mid);
        cs_n = 1'b0; waitn(8);
        chk("R2", oe_dn, 1'b1);
        chk("R4", do_dn, (|dn) | (|up));
        for (int k = 1; k <= 32; k++) begin
            sclk = 1'b1; waitn(8);
            if (k == 1)       chk("R6", do_dn, dn[0]);
            else if (k <= 16) chk("R7", do_dn, dn[k-1]);
            else              chk("R8", do_dn, up[k-17]);
            if (k == 3 && mid != 0) inject(mid, 16'h0000);   // R11 mid-read fault
            sclk = 1'b0; waitn(8);
        end
        cs_n = 1'b1; waitn(8);
        chk("R2", oe_dn, 1'b0);
        chk("R2", do_dn, 1'b0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        waitn(4);
        chk("R1", oe_dn, 1'b0);
        chk("R1", do_dn, 1'b0);
        rst = 1'b0; waitn(4);
        chk("R2", oe_dn, 1'b0);

        // Table walk: capture, flag, shift order, cascade (R3 R4 R6 R7 R8)
        for (int v = 0; v < 4; v++) begin
            inject(VEC[v][15:0], VEC[v][31:16]);
            waitn(2);
            read_chain(VEC[v][15:0], VEC[v][31:16], 16'h0000);
        end

        // R9: select-only probe keeps data, clocked read clears it
        inject(16'h0400, 16'h0000);
        flag_probe("R9", 1'b1);
        read_chain(16'h0400, 16'h0000, 16'h0000);
        flag_probe("R9", 1'b0);

        // R10: fault pulse placed on the clearing cycle
        cs_n = 1'b0; waitn(8);
        sclk = 1'b1;
        @(negedge clk); @(negedge clk);
        f_dn = 16'h0080;
        @(negedge clk);
        f_dn = 16'h0000;
        waitn(6);
        sclk = 1'b0; waitn(8);
        cs_n = 1'b1; waitn(8);
        flag_probe("R10", 1'b1);
        read_chain(16'h0080, 16'h0000, 16'h0000);

        // R11: fault during a read appears only in the next read
        inject(16'h0001, 16'h0000);
        read_chain(16'h0001, 16'h0000, 16'h0020);
        flag_probe("R11", 1'b1);
        read_chain(16'h0020, 16'h0000, 16'h0000);

        // R5: clock high at select, DI (upstream bit 0 = 1) must not pass
        inject(16'h0002, 16'h0001);
        sclk = 1'b1; waitn(8);
        cs_n = 1'b0; waitn(8);
        chk("R5", do_dn, 1'b0);
        sclk = 1'b0; waitn(8);
        chk("R5", do_dn, 1'b0);
        sclk = 1'b1; waitn(8);
        chk("R6", do_dn, 1'b0);
        sclk = 1'b0; waitn(8);
        sclk = 1'b1; waitn(8);
        chk("R7", do_dn, 1'b1);
        sclk = 1'b0; waitn(8);
        cs_n = 1'b1; waitn(8);
        flag_probe("R9", 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule